// File: doc/BRIEF.md
# Up-Counting Reloadable Event Timer

A 32-bit event timer that counts upward from a programmed value and flags an event when the count steps past all-ones. Software reaches it through a simple word-addressed register bus. To get an event after a delay, software writes the complement of that delay into the counter and sets the run bit. A count input from the functional clock domain gates each step, so the count rate does not depend on the bus clock.

Two modes exist. In single-shot mode the counter falls to zero on the wrap and the run bit clears itself. The timer then waits for software to load and start it again. In reload mode each wrap copies a separate reload register into the counter. This gives a periodic event. With a reload value of zero, reload mode becomes a free-running 32-bit count that software can read at any time. The overflow is latched in a status bit that software clears by writing a one. The interrupt line is driven from that status bit ANDed with an enable bit.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset every register (control, reload, counter, enable, status) reads zero and `irq_o` is low.
- R2: While the run bit (control bit 0) is 1, the counter rises by exactly one on every clock cycle in which `tick_en` is high. It keeps its value on cycles without `tick_en`.
- R3: A tick that finds the counter at 0xFFFFFFFF is an overflow and sets status bit 0. A start count of 0xFFFFFFFF minus N therefore overflows on tick N+1.
- R4: Single-shot mode is control bit 1 = 0. In this mode an overflow leaves the counter at 0 and clears the run bit. Further ticks then leave the counter unchanged.
- R5: Reload mode is control bit 1 = 1. In this mode an overflow loads the counter from the reload register and the run bit stays set. A reload value of 0xFFFFFFFF minus (P minus 1) gives one overflow every P ticks.
- R6: Writing 1 to status bit 0 clears it and writing 0 leaves it alone. If an overflow occurs in the same cycle as the clearing write, the status bit stays set.
- R7: `irq_o` is high in the cycle after status bit 0 and enable bit 0 are both 1. It is low in the cycle after either one is 0.
- R8: Writing 0 to the run bit freezes the counter. The enable register and the reload register keep their values.
- R9: A bus write to the counter takes effect in that cycle even if a tick arrives in the same cycle. That tick is discarded and causes no overflow.
- R10: With reload mode set, a reload value of 0 and a start count of 0, the counter reads the number of ticks applied since the start.
- R11: The byte offsets are: control 0x00, reload 0x04, counter 0x08, enable 0x0C, status 0x10. `bus_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the functional clock domain, one tick per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is an overflow tick and a write-one-to-clear of the status bit. The second is a tick and a direct write of the counter. The bench forces each pair by raising `tick_en` and the bus write on the same clock edge. For the first pair, the counter is preloaded to all-ones and the status bit must read back as still set. For the second pair, the counter must read back exactly the written value and must not be one higher.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL = 5'h00,
    OFS_RELD = 5'h04,
    OFS_CNT  = 5'h08,
    OFS_IEN  = 5'h0C,
    OFS_STS  = 5'h10
  } reg_ofs_e;

  localparam int BIT_RUN = 0;
  localparam int BIT_ARL = 1;
  localparam int BIT_OVF = 0;
  localparam int BIT_IEN = 0;
endpackage

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             arl,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reld,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic step;
  assign step = run && tick_en && !cnt_wr;
  assign wrap = step && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (wrap) begin
      cnt <= arl ? reld : '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              wrap,
  output logic              run,
  output logic              arl,
  output logic [DATA_W-1:0] reld,
  output logic              ien,
  output logic              sts,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic ctrl_wr, reld_wr, ien_wr, sts_wr;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign reld_wr = bus_wr && (bus_addr == OFS_RELD);
  assign cnt_wr  = bus_wr && (bus_addr == OFS_CNT);
  assign ien_wr  = bus_wr && (bus_addr == OFS_IEN);
  assign sts_wr  = bus_wr && (bus_addr == OFS_STS);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      arl <= 1'b0;
    end else if (ctrl_wr) begin
      run <= bus_wdata[BIT_RUN];
      arl <= bus_wdata[BIT_ARL];
    end else if (wrap && !arl) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reld <= '0;
    end else if (reld_wr) begin
      reld <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 1'b0;
    end else if (ien_wr) begin
      ien <= bus_wdata[BIT_IEN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 1'b0;
    end else if (wrap) begin
      sts <= 1'b1;
    end else if (sts_wr && bus_wdata[BIT_OVF]) begin
      sts <= 1'b0;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        rd_mux[BIT_RUN] = run;
        rd_mux[BIT_ARL] = arl;
      end
      OFS_RELD: rd_mux = reld;
      OFS_CNT:  rd_mux = cnt;
      OFS_IEN:  rd_mux[BIT_IEN] = ien;
      OFS_STS:  rd_mux[BIT_OVF] = sts;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic sts,
  input  logic ien,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= sts && ien;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic             run_q, arl_q, ien_q, sts_q, cnt_wr, wrap_evt;
  logic [CNT_W-1:0] reld_q, cnt_q;

  evt_timer_regs #(.DATA_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt_q), .wrap(wrap_evt),
    .run(run_q), .arl(arl_q), .reld(reld_q), .ien(ien_q), .sts(sts_q),
    .cnt_wr(cnt_wr), .bus_rdata(bus_rdata)
  );

  evt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .arl(arl_q), .tick_en(tick_en),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .reld(reld_q),
    .cnt(cnt_q), .wrap(wrap_evt)
  );

  evt_timer_irq u_irq (
    .clk(clk), .rst(rst), .sts(sts_q), .ien(ien_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic              irq_o,
  input logic              run,
  input logic              arl,
  input logic              ien,
  input logic              sts,
  input logic [CNT_W-1:0]  reld,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic w_cnt, w_ctrl, w_ien, w_reld;
  assign w_cnt  = bus_wr && (bus_addr == OFS_CNT);
  assign w_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign w_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign w_reld = bus_wr && (bus_addr == OFS_RELD);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run && tick_en && !w_cnt && cnt != TOP |=> cnt == $past(cnt) + 1'b1); // R2
  AST_OVF_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    run && tick_en && !w_cnt && cnt == TOP |=> sts); // R3
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    run && tick_en && !w_cnt && !w_ctrl && !arl && cnt == TOP |=> !run && cnt == '0); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    run && tick_en && !w_cnt && !w_ctrl && arl && cnt == TOP |=> run && cnt == $past(reld)); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    sts && ien |=> irq_o); // R7
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    !sts |=> !irq_o); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !run && !w_cnt |=> $stable(cnt)); // R8
  AST_STOP_KEEPS_IEN: assert property (@(posedge clk) disable iff (rst)
    w_ctrl && !w_ien && !w_reld |=> $stable(ien) && $stable(reld)); // R8
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    w_cnt |=> cnt == $past(bus_wdata)); // R9
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
  .run(run_q), .arl(arl_q), .ien(ien_q), .sts(sts_q),
  .reld(reld_q), .cnt(cnt_q)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, TK = 2'd2, IQ = 2'd3;
  localparam logic [4:0] A_C = 5'h00, A_L = 5'h04, A_N = 5'h08, A_E = 5'h0C, A_S = 5'h10;
  localparam int NV = 44;
  localparam logic [70:0] VEC [NV] = '{
    {WR, A_E, 32'd1, 32'd0},
    {WR, A_N, 32'hFFFFFFFD, 32'd0},
    {WR, A_C, 32'd1, 32'd0},
    {TK, A_C, 32'd2, 32'd0},
    {RD, A_N, 32'd0, 32'hFFFFFFFF},   // R2
    {IQ, A_C, 32'd0, 32'd0},          // R7
    {TK, A_C, 32'd1, 32'd0},
    {IQ, A_C, 32'd0, 32'd1},          // R7
    {RD, A_S, 32'd0, 32'd1},          // R3
    {RD, A_C, 32'd0, 32'd0},          // R4
    {RD, A_N, 32'd0, 32'd0},          // R4
    {TK, A_C, 32'd5, 32'd0},
    {RD, A_N, 32'd0, 32'd0},          // R4
    {WR, A_S, 32'd1, 32'd0},
    {IQ, A_C, 32'd0, 32'd0},          // R7
    {RD, A_S, 32'd0, 32'd0},          // R6
    {WR, A_L, 32'hFFFFFFFC, 32'd0},
    {WR, A_N, 32'hFFFFFFFC, 32'd0},
    {WR, A_C, 32'd3, 32'd0},
    {TK, A_C, 32'd4, 32'd0},
    {RD, A_N, 32'd0, 32'hFFFFFFFC},   // R5
    {RD, A_S, 32'd0, 32'd1},          // R5
    {WR, A_S, 32'd1, 32'd0},
    {TK, A_C, 32'd3, 32'd0},
    {RD, A_S, 32'd0, 32'd0},          // R5
    {TK, A_C, 32'd1, 32'd0},
    {RD, A_S, 32'd0, 32'd1},          // R5
    {RD, A_C, 32'd0, 32'd3},          // R5
    {WR, A_C, 32'd0, 32'd0},
    {TK, A_C, 32'd3, 32'd0},
    {RD, A_N, 32'd0, 32'hFFFFFFFC},   // R8
    {RD, A_E, 32'd0, 32'd1},          // R8
    {WR, A_L, 32'd0, 32'd0},
    {WR, A_N, 32'd0, 32'd0},
    {WR, A_C, 32'd3, 32'd0},
    {TK, A_C, 32'd7, 32'd0},
    {RD, A_N, 32'd0, 32'd7},          // R10
    {WR, A_C, 32'd0, 32'd0},
    {WR, A_E, 32'd0, 32'd0},
    {IQ, A_C, 32'd0, 32'd0},          // R7
    {WR, A_E, 32'd1, 32'd0},
    {IQ, A_C, 32'd0, 32'd1},          // R7
    {WR, A_S, 32'd1, 32'd0},
    {IQ, A_C, 32'd0, 32'd0}           // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd("R1 ctrl", A_C, 32'd0);
    rd("R1 reload", A_L, 32'd0);
    rd("R1 counter", A_N, 32'd0);
    rd("R1 enable", A_E, 32'd0);
    rd("R1 status", A_S, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        WR: wr(a, d);
        RD: rd($sformatf("R11 vector %0d", i), a, e);
        TK: ticks(int'(d));
        default: begin
          @(negedge clk);
          check($sformatf("R7 vector %0d", i), {31'd0, irq_o}, e);
        end
      endcase
    end

    // R6: overflow and status clear in the same cycle, overflow wins
    wr(A_C, 32'd0);
    wr(A_S, 32'd1);
    wr(A_N, 32'hFFFFFFFF);
    wr(A_C, 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_S; bus_wdata = 32'd1; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd("R6 overflow beats clear", A_S, 32'd1);
    rd("R4 one-shot cleared run", A_C, 32'd0);

    // R9: counter write beats a same-cycle tick
    wr(A_S, 32'd1);
    wr(A_L, 32'd0);
    wr(A_C, 32'd3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_N; bus_wdata = 32'd100; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd("R9 write wins over tick", A_N, 32'd100);
    wr(A_N, 32'hFFFFFFFF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_N; bus_wdata = 32'hFFFFFFFF; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd("R9 discarded tick gives no overflow", A_S, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule